// File: doc/BRIEF.md
# Stack-Pointer Load Unit

This block executes one form of load: a 16-bit instruction that reads a 32-bit word from memory at an address taken from a 24-bit stack pointer, and writes the low 24 bits of that word into one of eight registers. The most significant byte of the word is dropped. The instruction can leave the pointer unchanged. It can also step the pointer up after the access, step it down after the access, or step it down before the access.

Zero, one or two extension prefixes may come before the instruction. The decoder upstream reports how many were seen and supplies their immediate. With a prefix, the immediate is added to the pointer to form the access address, and it replaces the default step of 4 in any pointer update. The plain form without a prefix finishes in the cycle it is accepted. All other forms take a second cycle. During that second cycle `busy` is high, and the block latches everything it needs, so the inputs are free to change. Instruction fetch, prefix decoding and the register file itself sit outside the block.

Top module: `sp_load_unit`

## Requirements
- R1: An instruction word is accepted only when bits 15:10 equal 001111 and bits 4:0 equal 11000. Any other word causes no memory read, no register write, no pointer write and no `done`.
- R2: Bits 9:7 give the destination index on `reg_idx`. `reg_wdata` carries `mem_rdata[23:0]`, and bits 31:24 of the read word reach no output.
- R3: Bits 6:5 select the update mode: 00 keeps the pointer, 01 post-increments, 11 post-decrements and 10 pre-decrements. Mode 00 never asserts `sp_we`.
- R4: With `ext_count` = 0, the access address is `sp_in` for modes 00, 01 and 11, and `sp_in`-4 for mode 10. The updated pointer is `sp_in`+4 for mode 01 and `sp_in`-4 for modes 11 and 10.
- R5: With `ext_count` = 1, the immediate is `ext_imm[12:0]` zero-extended, and the upper bits of `ext_imm` are ignored. The access address is the pointer plus this immediate, and the immediate is also the update step.
- R6: With `ext_count` = 2 or 3, the immediate is the full 24-bit `ext_imm`, used for both the address offset and the step.
- R7: In pre-decrement form with a prefix, the pointer is first reduced by the immediate and the access address is the reduced pointer plus the immediate. The address therefore equals the original pointer, and `sp_wdata` is the original pointer minus the immediate.
- R8: All address and pointer arithmetic is on 24 bits and wraps modulo 2^24.
- R9: The plain form without a prefix raises `mem_rd`, `reg_we` and `done` in its accept cycle, and `busy` stays low. Every other accepted form raises `busy` in the next cycle and produces all of its outputs, and `done`, in that cycle.
- R10: `sp_we` is high only for update modes, exactly once per instruction, in the cycle `done` is high.
- R11: `done` lasts one cycle per instruction. An instruction presented while `busy` is high is not accepted and produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 16 | Instruction word |
| ext_count | input | 2 | Number of extension prefixes before the instruction (0..3) |
| ext_imm | input | 24 | Immediate assembled from the prefixes |
| sp_in | input | 24 | Current stack pointer |
| mem_rdata | input | 32 | Read data for `mem_addr`, valid in the same cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory read address |
| reg_we | output | 1 | Destination register write enable |
| reg_idx | output | 3 | Destination register index |
| reg_wdata | output | 24 | Value written to the destination register |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 24 | New stack pointer value |
| busy | output | 1 | Second cycle of a two-cycle form is in progress |
| done | output | 1 | Instruction completes this cycle |

## Verification
A result of the plain form is due in the cycle its word is presented. A result of a prefixed or updating form is due exactly one cycle later. The bench drives inputs just after a rising edge, records the expected completion cycle next to each expected item, and the monitor samples on the falling edge, comparing the cycle number as well as the data. After acceptance it changes `sp_in` to an unrelated value, so a second-cycle result that still followed the live input would be caught. A `done` with no queued item flags an ignored word that was wrongly executed.

// File: rtl/sp_load_pkg.sv
// Package: shared encodings and types for the stack-pointer load unit.
// Assumes the fixed 16-bit instruction layout: opcode bits, destination, mode.
package sp_load_pkg;

    localparam logic [5:0] OPC_HIGH = 6'b001111;   // bits 15:10
    localparam logic [4:0] OPC_LOW  = 5'b11000;    // bits 4:0
    localparam int         DST_W    = 3;           // eight destinations

    typedef enum logic [1:0] {
        UPD_NONE     = 2'b00,
        UPD_POST_INC = 2'b01,
        UPD_PRE_DEC  = 2'b10,
        UPD_POST_DEC = 2'b11
    } upd_mode_e;

    typedef struct packed {
        logic [DST_W-1:0] dst;
        upd_mode_e        mode;
    } ld_fields_t;

endpackage

// File: rtl/sp_load_decode.sv
// Module: sp_load_decode
// Purpose: checks the fixed opcode bits and extracts destination and mode.
// Assumes: purely combinational; the caller qualifies the match with valid.
module sp_load_decode
    import sp_load_pkg::*;
(
    input  logic [15:0] word,
    output logic        hit,
    output ld_fields_t  fields
);

    // Opcode match and field extraction.
    always_comb begin
        hit         = (word[15:10] == OPC_HIGH) && (word[4:0] == OPC_LOW);
        fields.dst  = word[9:7];
        fields.mode = upd_mode_e'(word[6:5]);
    end

endmodule

// File: rtl/sp_load_agu.sv
// Module: sp_load_agu
// Purpose: forms the access address and the updated stack pointer.
// Assumes: ext_cnt 0 = no prefix, 1 = short immediate, 2/3 = full immediate;
//          the short immediate is zero-extended; arithmetic wraps at ADDR_W.
module sp_load_agu
    import sp_load_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SHORT_IMM_W = 13,
    parameter int DEF_STEP    = 4
) (
    input  upd_mode_e         mode,
    input  logic [1:0]        ext_cnt,
    input  logic [ADDR_W-1:0] ext_imm,
    input  logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] new_sp,
    output logic              updates
);

    localparam logic [ADDR_W-1:0] STEP_DEFAULT = ADDR_W'(DEF_STEP);

    logic [ADDR_W-1:0] short_imm;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] sp_up;
    logic [ADDR_W-1:0] sp_down;

    // Short immediate width picks zero-extension or a pass-through.
    generate
        if (SHORT_IMM_W < ADDR_W) begin : g_short_ext
            assign short_imm = {{(ADDR_W-SHORT_IMM_W){1'b0}}, ext_imm[SHORT_IMM_W-1:0]};
        end else begin : g_short_full
            assign short_imm = ext_imm;
        end
    endgenerate

    // Offset and step chosen by prefix count.
    always_comb begin
        unique case (ext_cnt)
            2'd0:    begin offset = '0;        step = STEP_DEFAULT; end
            2'd1:    begin offset = short_imm; step = short_imm;    end
            default: begin offset = ext_imm;   step = ext_imm;      end
        endcase
    end

    assign sp_up   = sp + step;
    assign sp_down = sp - step;

    // Address and pointer result per update mode.
    always_comb begin
        unique case (mode)
            UPD_NONE:     begin addr = sp + offset;      new_sp = sp;      updates = 1'b0; end
            UPD_POST_INC: begin addr = sp + offset;      new_sp = sp_up;   updates = 1'b1; end
            UPD_POST_DEC: begin addr = sp + offset;      new_sp = sp_down; updates = 1'b1; end
            default:      begin addr = sp_down + offset; new_sp = sp_down; updates = 1'b1; end
        endcase
    end

endmodule

// File: rtl/sp_load_ctrl.sv
// Module: sp_load_ctrl
// Purpose: accepts instructions and sequences the optional second cycle.
// Assumes: synchronous active-low reset; accepts only while idle.
module sp_load_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req,        // valid word with matching opcode
    input  logic two_cycle,  // accepted form needs a second cycle
    output logic busy,
    output logic capture,    // latch operands this cycle
    output logic fire        // execute and complete this cycle
);

    typedef enum logic {ST_IDLE, ST_EXEC} ctrl_state_e;

    ctrl_state_e state;
    logic        accept;

    assign accept  = req && (state == ST_IDLE);
    assign capture = accept && two_cycle;
    assign fire    = (accept && !two_cycle) || (state == ST_EXEC);
    assign busy    = (state == ST_EXEC);

    // State register: enter EXEC on capture, always leave it after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (capture)
            state <= ST_EXEC;
        else if (state == ST_EXEC)
            state <= ST_IDLE;
    end

endmodule

// File: rtl/sp_load_unit.sv
// Module: sp_load_unit (top)
// Purpose: executes the stack-pointer relative load with optional prefixes
//          and pointer update; single cycle for the plain unprefixed form.
// Assumes: memory returns mem_rdata combinationally for mem_addr; the
//          register file and pointer register consume the write strobes.
module sp_load_unit
    import sp_load_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 32,
    parameter int SHORT_IMM_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    input  logic [1:0]        ext_count,
    input  logic [ADDR_W-1:0] ext_imm,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              reg_we,
    output logic [DST_W-1:0]  reg_idx,
    output logic [ADDR_W-1:0] reg_wdata,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_wdata,
    output logic              busy,
    output logic              done
);

    localparam int DROP_W = DATA_W - ADDR_W;

    logic              hit;
    ld_fields_t        cur_fields;
    logic              two_cycle;
    logic              capture;
    logic              fire;

    ld_fields_t        h_fields;
    logic [1:0]        h_ext_cnt;
    logic [ADDR_W-1:0] h_imm;
    logic [ADDR_W-1:0] h_sp;

    ld_fields_t        sel_fields;
    logic [1:0]        sel_ext_cnt;
    logic [ADDR_W-1:0] sel_imm;
    logic [ADDR_W-1:0] sel_sp;

    logic [ADDR_W-1:0] agu_addr;
    logic [ADDR_W-1:0] agu_new_sp;
    logic              agu_updates;
    logic [DROP_W-1:0] unused_top_byte;

    sp_load_decode u_decode (
        .word   (instr),
        .hit    (hit),
        .fields (cur_fields)
    );

    assign two_cycle = (ext_count != 2'd0) || (cur_fields.mode != UPD_NONE);

    sp_load_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (instr_valid && hit),
        .two_cycle (two_cycle),
        .busy      (busy),
        .capture   (capture),
        .fire      (fire)
    );

    // Operand hold registers for the second cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_fields  <= '0;
            h_ext_cnt <= '0;
            h_imm     <= '0;
            h_sp      <= '0;
        end else if (capture) begin
            h_fields  <= cur_fields;
            h_ext_cnt <= ext_count;
            h_imm     <= ext_imm;
            h_sp      <= sp_in;
        end
    end

    // Operand select: held copy while busy, live inputs otherwise.
    always_comb begin
        if (busy) begin
            sel_fields  = h_fields;
            sel_ext_cnt = h_ext_cnt;
            sel_imm     = h_imm;
            sel_sp      = h_sp;
        end else begin
            sel_fields  = cur_fields;
            sel_ext_cnt = ext_count;
            sel_imm     = ext_imm;
            sel_sp      = sp_in;
        end
    end

    sp_load_agu #(
        .ADDR_W      (ADDR_W),
        .SHORT_IMM_W (SHORT_IMM_W),
        .DEF_STEP    (4)
    ) u_agu (
        .mode    (sel_fields.mode),
        .ext_cnt (sel_ext_cnt),
        .ext_imm (sel_imm),
        .sp      (sel_sp),
        .addr    (agu_addr),
        .new_sp  (agu_new_sp),
        .updates (agu_updates)
    );

    assign unused_top_byte = mem_rdata[DATA_W-1:ADDR_W];

    // Output gating: everything is quiet unless the instruction fires.
    always_comb begin
        mem_rd    = fire;
        reg_we    = fire;
        done      = fire;
        mem_addr  = fire ? agu_addr : '0;
        reg_idx   = fire ? sel_fields.dst : '0;
        reg_wdata = fire ? mem_rdata[ADDR_W-1:0] : '0;
        sp_we     = fire && agu_updates;
        sp_wdata  = (fire && agu_updates) ? agu_new_sp : '0;
    end

endmodule

// File: rtl/sp_load_unit_checker.sv
// Module: sp_load_unit_checker
// Purpose: temporal properties of the load unit's handshake and write strobes.
// Assumes: bound to sp_load_unit; reset is synchronous and active low.
module sp_load_unit_checker (
    input logic clk,
    input logic rst_n,
    input logic instr_valid,
    input logic mem_rd,
    input logic reg_we,
    input logic sp_we,
    input logic busy,
    input logic done
);

    // R10: pointer write only in the completing cycle.
    assert_sp_we_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> done);

    // R10: pointer updates only occur in the second cycle of a two-cycle form.
    assert_sp_we_second_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> busy);

    // R9: a busy cycle always completes the held instruction.
    assert_busy_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> done);

    // R11: after the second cycle the unit is idle again.
    assert_exec_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R1: without a presented word and outside the second cycle nothing completes.
    assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !busy) |-> !done);

    // R2: a register write always comes with its memory read.
    assert_write_has_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> mem_rd);

endmodule

bind sp_load_unit sp_load_unit_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .mem_rd      (mem_rd),
    .reg_we      (reg_we),
    .sp_we       (sp_we),
    .busy        (busy),
    .done        (done)
);

// File: tb/sp_load_unit_test.sv
`timescale 1ns/1ps
module sp_load_unit_test;

    logic        clk;
    logic        rst_n;
    logic        instr_valid;
    logic [15:0] instr;
    logic [1:0]  ext_count;
    logic [23:0] ext_imm;
    logic [23:0] sp_in;
    logic [31:0] mem_rdata;
    logic        mem_rd;
    logic [23:0] mem_addr;
    logic        reg_we;
    logic [2:0]  reg_idx;
    logic [23:0] reg_wdata;
    logic        sp_we;
    logic [23:0] sp_wdata;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 0;

    typedef struct packed {
        logic [23:0] addr;
        logic [23:0] data;
        logic [23:0] nsp;
        logic        upd;
        logic [2:0]  idx;
        logic [31:0] due;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    sp_load_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .ext_count   (ext_count),
        .ext_imm     (ext_imm),
        .sp_in       (sp_in),
        .mem_rdata   (mem_rdata),
        .mem_rd      (mem_rd),
        .mem_addr    (mem_addr),
        .reg_we      (reg_we),
        .reg_idx     (reg_idx),
        .reg_wdata   (reg_wdata),
        .sp_we       (sp_we),
        .sp_wdata    (sp_wdata),
        .busy        (busy),
        .done        (done)
    );

    // 50 MHz clock
    initial clk = 0;
    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: a nonzero top byte that must be discarded.
    assign mem_rdata = {mem_addr[7:0] ^ 8'hC3, mem_addr ^ 24'h13579B};

    function automatic logic [15:0] mk(input logic [2:0] d, input logic [1:0] m);
        return {6'b001111, d, m, 5'b11000};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Driver: presents one word, pushes the expected item if it should execute.
    task automatic issue(input logic [15:0] w, input logic [1:0] n, input logic [23:0] imm,
                         input logic [23:0] sp, input bit stall_word, input string tag);
        logic        ok;
        logic        two;
        logic [1:0]  m;
        logic [23:0] iv;
        logic [23:0] st;
        logic [23:0] dn;
        exp_t        e;
        @(posedge clk); #1;
        instr_valid = 1; instr = w; ext_count = n; ext_imm = imm; sp_in = sp;
        ok  = (w[15:10] == 6'b001111) && (w[4:0] == 5'b11000);
        m   = w[6:5];
        two = (n != 0) || (m != 2'b00);
        iv  = (n == 0) ? 24'd0 : (n == 1) ? {11'd0, imm[12:0]} : imm;
        st  = (n == 0) ? 24'd4 : iv;
        dn  = sp - st;
        e.idx = w[9:7];
        e.due = cyc + (two ? 1 : 0);
        case (m)
            2'b00:   begin e.addr = sp + iv; e.nsp = 24'd0;   e.upd = 0; end
            2'b01:   begin e.addr = sp + iv; e.nsp = sp + st; e.upd = 1; end
            2'b11:   begin e.addr = sp + iv; e.nsp = dn;      e.upd = 1; end
            default: begin e.addr = dn + iv; e.nsp = dn;      e.upd = 1; end
        endcase
        e.data = e.addr ^ 24'h13579B;
        if (ok) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        sp_in = 24'hBAD0BA; ext_imm = 24'h0F0F0F; ext_count = 2'd3;
        if (stall_word) instr = mk(3'd5, 2'b00);  // R11: presented while busy
        else instr_valid = 0;
        if (ok && two) begin
            @(posedge clk); #1;
            instr_valid = 0;
        end
        instr_valid = 0;
    endtask

    // Monitor: compares each completion against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL R1/R11 unexpected done: actual 1 expected 0 (addr %h)", mem_addr);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " R9 cycle"},     cyc,        e.due);
                check({t, " R4 addr"},      {8'd0, mem_addr},  {8'd0, e.addr});
                check({t, " R2 idx"},       {29'd0, reg_idx},  {29'd0, e.idx});
                check({t, " R2 data"},      {8'd0, reg_wdata}, {8'd0, e.data});
                check({t, " R10 sp_we"},    {31'd0, sp_we},    {31'd0, e.upd});
                if (e.upd) check({t, " R8 sp_wdata"}, {8'd0, sp_wdata}, {8'd0, e.nsp});
                check({t, " R9 rd/we"},     {30'd0, mem_rd, reg_we}, 32'd3);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; instr_valid = 0; instr = 0; ext_count = 0; ext_imm = 0; sp_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset busy/done",  {30'd0, busy, done}, 32'd0);
        check("reset strobes",    {29'd0, mem_rd, reg_we, sp_we}, 32'd0);
        @(posedge clk); #1 rst_n = 1;

        // R3 R4 R9: plain, no prefix, single cycle
        issue(mk(3'd3, 2'b00), 2'd0, 24'h0, 24'h001000, 0, "R3 plain");
        // R5: short immediate, upper ext_imm bits ignored
        issue(mk(3'd1, 2'b00), 2'd1, 24'hF0FFFF, 24'h002000, 0, "R5 plain ext1");
        // R4: post-increment
        issue(mk(3'd7, 2'b01), 2'd0, 24'h0, 24'h000100, 0, "R4 post-inc");
        // R8: post-decrement wraps below zero
        issue(mk(3'd2, 2'b11), 2'd0, 24'h0, 24'h000002, 0, "R8 post-dec wrap");
        // R4 R8: pre-decrement from zero
        issue(mk(3'd4, 2'b10), 2'd0, 24'h0, 24'h000000, 0, "R4 pre-dec wrap");
        // R6 R8: full immediate, post-increment wrapping above the top
        issue(mk(3'd6, 2'b01), 2'd2, 24'h123456, 24'hF00000, 0, "R6 post-inc ext2");
        // R7: prefixed pre-decrement
        issue(mk(3'd0, 2'b10), 2'd1, 24'h000100, 24'h002000, 0, "R7 pre-dec ext1");
        // R6: full immediate post-decrement
        issue(mk(3'd5, 2'b11), 2'd2, 24'h000FF0, 24'h400000, 0, "R6 post-dec ext2");
        // R6: three prefixes act as two
        issue(mk(3'd1, 2'b00), 2'd3, 24'h800000, 24'h000010, 0, "R6 ext3");
        // R1: opcode mismatches are ignored
        issue(mk(3'd2, 2'b00) ^ 16'h0400, 2'd0, 24'h0, 24'h000300, 0, "R1 bad hi");
        issue(mk(3'd2, 2'b01) ^ 16'h0001, 2'd0, 24'h0, 24'h000300, 0, "R1 bad lo");
        // R11: word presented while busy is not accepted
        issue(mk(3'd3, 2'b01), 2'd0, 24'h0, 24'h000040, 1, "R11 busy ignore");
        // R9: back-to-back single-cycle forms
        issue(mk(3'd6, 2'b00), 2'd0, 24'h0, 24'hABCDEF, 0, "R9 b2b a");
        issue(mk(3'd2, 2'b00), 2'd0, 24'h0, 24'h000004, 0, "R9 b2b b");

        repeat (4) @(posedge clk);
        check("R9 all results delivered", exp_q.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule